// File: doc/BRIEF.md
# IQ Digital Gain Shifter

This block scales a stream of signed complex samples by a power of two chosen by a host, and sits between a down-converter and a matched filter. A 4-bit control word carries a direction bit and a 3-bit shift amount. In the amplify direction each channel is shifted left and then clamped to the signed sample range. In the attenuate direction each channel is shifted right arithmetically, which rounds toward negative infinity.

Results are registered and come out one clock after a valid input, together with a delayed valid strobe. An 8-bit counter records how many samples were clipped. A sample counts once, whether one channel or both clipped, and the counter stops at its maximum instead of wrapping. The control word may change between any two samples. Each sample is scaled with the control word present in the cycle that sample is accepted.

Top module: `iq_gain_shifter`

## Requirements
- R1: `gain_i` bit 3 selects the direction: 0 shifts left (amplify) and 1 shifts right (attenuate). Bits 2:0 give the shift amount 0..7, and a left shift of 0 passes data through unchanged.
- R2: On a left shift, each channel clamps on its own: a result above 32767 gives 32767 and a result below -32768 gives -32768. Other results are exact.
- R3: A right shift is arithmetic and rounds toward negative infinity (-1>>1 = -1, -3>>1 = -2, -32768>>7 = -256).
- R4: `valid_o` rises one clock after a cycle with `valid_i` high and carries that sample's result. `valid_o` is low in the cycle after one with `valid_i` low.
- R5: The clip count rises by exactly one for each valid sample in which at least one channel clamped. Samples that do not clamp leave it unchanged.
- R6: The clip count saturates at 255 and never wraps.
- R7: Reset clears `i_o`, `q_o`, `valid_o` and `clip_cnt_o` to zero.
- R8: While `valid_i` is low, `i_o`, `q_o` and `clip_cnt_o` hold their values.
- R9: The control word is applied per sample, so a change between consecutive samples takes effect on the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| i_i | input | 16 | Signed in-phase sample |
| q_i | input | 16 | Signed quadrature sample |
| valid_i | input | 1 | Input sample strobe |
| gain_i | input | 4 | Bit 3 direction (1 = right), bits 2:0 shift amount |
| i_o | output | 16 | Scaled in-phase sample |
| q_o | output | 16 | Scaled quadrature sample |
| valid_o | output | 1 | Output strobe, one cycle after input |
| clip_cnt_o | output | 8 | Saturating count of clipped samples |

## Verification
A wrong shift or clamp decision shows on `i_o`/`q_o` in the very cycle `valid_o` marks that sample, so a sweep of every control code against edge values catches it one clock after input. A faulty clip flag or counter update shows as a count off by one or more after the next valid sample. A lost saturation stop shows only once 255 is passed, so the bench drives the counter past its limit. Holding faults show as output changes in cycles without valid.

// File: rtl/iq_gain_pkg.sv
package iq_gain_pkg;
  parameter int unsigned SAMPLE_W = 16;
  parameter int unsigned AMT_W    = 3;
  parameter int unsigned CNT_W    = 8;
  localparam int unsigned MAX_SHIFT = (1 << AMT_W) - 1;
  localparam int unsigned WIDE_W    = SAMPLE_W + MAX_SHIFT + 1;

  typedef struct packed {
    logic             dir_right;
    logic [AMT_W-1:0] amt;
  } gain_word_t;
endpackage

// File: rtl/iq_gain_lane.sv
module iq_gain_lane
  import iq_gain_pkg::*;
#(
  parameter int unsigned W   = SAMPLE_W,
  parameter int unsigned AW  = AMT_W
) (
  input  logic signed [W-1:0]  din_i,
  input  logic                 dir_right_i,
  input  logic        [AW-1:0] amt_i,
  output logic signed [W-1:0]  dout_o,
  output logic                 clip_o
);
  localparam int unsigned XW = W + (1 << AW);
  localparam logic signed [XW-1:0] POS_LIM = XW'((1 << (W-1)) - 1);
  localparam logic signed [XW-1:0] NEG_LIM = -XW'(1 << (W-1));

  logic signed [XW-1:0] wide;
  logic signed [XW-1:0] shl;
  logic signed [W-1:0]  shr;

  // full-width left shift keeps every bit for the range test
  always_comb begin
    wide = XW'(din_i);
    shl  = wide <<< amt_i;
    shr  = din_i >>> amt_i;
    clip_o = 1'b0;
    if (dir_right_i) begin
      dout_o = shr;
    end else if (shl > POS_LIM) begin
      dout_o = POS_LIM[W-1:0];
      clip_o = 1'b1;
    end else if (shl < NEG_LIM) begin
      dout_o = NEG_LIM[W-1:0];
      clip_o = 1'b1;
    end else begin
      dout_o = shl[W-1:0];
    end
  end
endmodule

// File: rtl/iq_clip_counter.sv
module iq_clip_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_o <= '0;
    else if (inc_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/iq_gain_shifter.sv
module iq_gain_shifter
  import iq_gain_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [SAMPLE_W-1:0] i_i,
  input  logic signed [SAMPLE_W-1:0] q_i,
  input  logic                       valid_i,
  input  logic [AMT_W:0]             gain_i,
  output logic signed [SAMPLE_W-1:0] i_o,
  output logic signed [SAMPLE_W-1:0] q_o,
  output logic                       valid_o,
  output logic [CNT_W-1:0]           clip_cnt_o
);
  localparam int unsigned NLANE = 2;

  gain_word_t                 gw;
  logic signed [SAMPLE_W-1:0] lane_in  [NLANE];
  logic signed [SAMPLE_W-1:0] lane_out [NLANE];
  logic        [NLANE-1:0]    lane_clip;
  logic                       sample_clip;

  assign gw         = gain_word_t'(gain_i);
  assign lane_in[0] = i_i;
  assign lane_in[1] = q_i;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    iq_gain_lane #(.W(SAMPLE_W), .AW(AMT_W)) u_lane (
      .din_i       (lane_in[g]),
      .dir_right_i (gw.dir_right),
      .amt_i       (gw.amt),
      .dout_o      (lane_out[g]),
      .clip_o      (lane_clip[g])
    );
  end

  // one increment per sample regardless of how many lanes clipped
  assign sample_clip = valid_i && (|lane_clip);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_o     <= '0;
      q_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        i_o <= lane_out[0];
        q_o <= lane_out[1];
      end
    end
  end

  iq_clip_counter #(.CW(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (sample_clip),
    .cnt_o  (clip_cnt_o)
  );
endmodule

// File: rtl/iq_gain_shifter_chk.sv
module iq_gain_shifter_chk
  import iq_gain_pkg::*;
(
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic signed [SAMPLE_W-1:0] i_i,
  input logic                       valid_i,
  input logic [AMT_W:0]             gain_i,
  input logic signed [SAMPLE_W-1:0] i_o,
  input logic signed [SAMPLE_W-1:0] q_o,
  input logic                       valid_o,
  input logic [CNT_W-1:0]           clip_cnt_o
);
  // R4
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R4
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(i_o) && $stable(q_o) && $stable(clip_cnt_o)));
  // R5
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (clip_cnt_o == $past(clip_cnt_o) || clip_cnt_o == $past(clip_cnt_o) + 1'b1));
  // R6
  cnt_nowrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clip_cnt_o == {CNT_W{1'b1}}) |=> (clip_cnt_o == {CNT_W{1'b1}}));
  // R1
  pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && gain_i == '0) |=> (i_o == $past(i_i)));
  // R3
  shr_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && gain_i[AMT_W]) |=> (i_o[SAMPLE_W-1] == $past(i_i[SAMPLE_W-1])));
endmodule

bind iq_gain_shifter iq_gain_shifter_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .i_i        (i_i),
  .valid_i    (valid_i),
  .gain_i     (gain_i),
  .i_o        (i_o),
  .q_o        (q_o),
  .valid_o    (valid_o),
  .clip_cnt_o (clip_cnt_o)
);

// File: tb/sim_iq_gain_shifter.sv
`timescale 1ns/1ps
module sim_iq_gain_shifter;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic signed [15:0] i_i = '0, q_i = '0;
  logic valid_i = 1'b0;
  logic [3:0] gain_i = '0;
  logic signed [15:0] i_o, q_o;
  logic valid_o;
  logic [7:0] clip_cnt_o;

  int checks = 0, failures = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  iq_gain_shifter u0 (.*);

  function automatic int model(input int x, input logic [3:0] g, output bit clip);
    int r;
    clip = 0;
    if (g[3]) r = x >>> g[2:0];
    else begin
      r = x * (1 << g[2:0]);
      if (r > 32767) begin r = 32767; clip = 1; end
      else if (r < -32768) begin r = -32768; clip = 1; end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, result sampled after next posedge
  task automatic send(input int a, input int b, input logic [3:0] g, input string req);
    bit ca, cb;
    int ea, eb;
    ea = model(a, g, ca);
    eb = model(b, g, cb);
    if ((ca || cb) && exp_cnt < 255) exp_cnt++;
    @(negedge clk_i);
    i_i = 16'(a); q_i = 16'(b); gain_i = g; valid_i = 1'b1;
    @(posedge clk_i); #1;
    chk(valid_o == 1'b1, "R4", int'(valid_o), 1);
    chk(int'(i_o) == ea, req, int'(i_o), ea);
    chk(int'(q_o) == eb, req, int'(q_o), eb);
    chk(int'(clip_cnt_o) == exp_cnt, "R5", int'(clip_cnt_o), exp_cnt);
    @(negedge clk_i); valid_i = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int vals[10] = '{0, 1, -1, 3, -3, 255, -256, 4095, -4096, 32767};
    int last_i;
    repeat (3) @(posedge clk_i);
    #1;
    // R7 reset state
    chk(i_o == 0 && q_o == 0 && valid_o == 0 && clip_cnt_o == 0, "R7", int'(clip_cnt_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R1 R2 R3 sweep every gain code against edge values
    for (int g = 0; g < 16; g++) begin
      for (int k = 0; k < 10; k++) begin
        send(vals[k], -32768 + k, 4'(g), g[3] ? "R3" : (g == 0 ? "R1" : "R2"));
      end
    end
    // R2 independent per-lane clamp: one lane clips, other exact
    send(300, -50, 4'b0111, "R2");
    send(-300, 100, 4'b0111, "R2");
    // R3 specific floors
    send(-1, -3, 4'b1001, "R3");
    send(32767, -32768, 4'b1111, "R3");

    // R9 consecutive samples with changing gain
    @(negedge clk_i);
    i_i = 16'sd1000; q_i = 16'sd1000; gain_i = 4'b0001; valid_i = 1'b1;
    @(posedge clk_i); #1;
    chk(i_o == 2000, "R9", int'(i_o), 2000);
    @(negedge clk_i); gain_i = 4'b1001;
    @(posedge clk_i); #1;
    chk(i_o == 500, "R9", int'(i_o), 500);
    @(negedge clk_i); valid_i = 1'b0;
    @(posedge clk_i); #1;
    chk(valid_o == 0, "R4", int'(valid_o), 0);

    // R8 hold: drive clipping data without valid
    last_i = int'(i_o);
    @(negedge clk_i); i_i = 16'sd20000; gain_i = 4'b0111;
    repeat (3) @(posedge clk_i); #1;
    chk(int'(i_o) == last_i, "R8", int'(i_o), last_i);
    chk(int'(clip_cnt_o) == exp_cnt, "R8", int'(clip_cnt_o), exp_cnt);

    // R6 saturation past 255
    for (int n = 0; n < 300; n++) send(20000, 20000, 4'b0111, "R6");
    chk(clip_cnt_o == 8'd255, "R6", int'(clip_cnt_o), 255);

    // R7 reset clears again
    @(negedge clk_i); rst_ni = 1'b0; #1;
    chk(i_o == 0 && q_o == 0 && valid_o == 0 && clip_cnt_o == 0, "R7", int'(clip_cnt_o), 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule